// File: doc/BRIEF.md
# Timer Interrupt Routing Selector

This block takes the request outputs of three event timers and two older interrupt sources, an interval timer and a real-time clock. It places them on the input lines of two interrupt controllers. The first is a 16-line legacy controller. The second is a 24-line I/O interrupt controller.

A single mode input chooses between two routings. In replacement mode, timers 0 and 1 take over fixed lines and the two older sources are silenced. In standard mode, every timer is placed by its own route field, and the older sources keep their usual lines.

Each timer has its own settings:
- A route field, which is a 5-bit binary I/O line number.
- A capability mask, which is a parameter that permits only lines 20 to 23.
- A trigger-mode bit.

A timer in level mode holds its line for as long as its request is high. Several level requests that land on the same line are ORed together. A timer in edge mode is served by a small trigger state machine per channel, which has two states:
- `TRIG_ARMED`: the request was low at the last clock edge.
- `TRIG_FIRED`: the request was high at the last clock edge.

The machine moves from ARMED to FIRED when the request is sampled high, and from FIRED to ARMED when it is sampled low. An edge timer sends a one-cycle pulse only while the machine is ARMED and the request is high.

A global mask input forces every output line low. Software is expected to set the mask before it changes the mode, so that a source that is already asserted cannot produce a spurious request. Every output is registered, so each output reflects the inputs present at the previous rising clock edge.

Top module: `tmr_irq_router`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset with all inputs idle, every bit of `pic_irq` and `io_irq` is 0.
- R2: With `legacy_replace`=1, a request from timer 0 sets `pic_irq[0]` and `io_irq[2]`, and `pit_irq` has no effect on any output.
- R3: With `legacy_replace`=1, a request from timer 1 sets `pic_irq[8]` and `io_irq[8]`, and `rtc_irq` has no effect on any output.
- R4: With `legacy_replace`=1, timer 2 still drives the I/O line given by its route field (bits [14:10] of `tmr_route`) and drives no legacy-controller line.
- R5: With `legacy_replace`=0, timer t drives `io_irq[n]`, where n is `tmr_route[t*5 +: 5]`, and no timer drives any `pic_irq` line.
- R6: With `legacy_replace`=0, `pit_irq` drives `pic_irq[0]` and `io_irq[2]`, and `rtc_irq` drives `pic_irq[8]` and `io_irq[8]`.
- R7: A route value outside 20 to 23, including values of 24 to 31 that name no line, drives no output line. Each timer drives at most one I/O line.
- R8: When `tmr_edge[t]`=0, timer t's line follows its request level, and requests that share a line are ORed.
- R9: When `tmr_edge[t]`=1, a request sampled high, where the same request was sampled low at the edge before (or where reset came just before), gives exactly one cycle of output. No further output follows until the request has been sampled low.
- R10: When `irq_mask`=1, every output is 0 in the following cycle. An edge pulse that falls while the mask is set is lost.
- R11: Outputs are registered, with a latency of one clock edge from input to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_replace | input | 1 | 1 selects replacement routing, 0 selects standard routing |
| irq_mask | input | 1 | Forces all outputs low |
| tmr_irq | input | 3 | Request from each event timer |
| tmr_edge | input | 3 | Per-timer trigger mode: 1 is edge, 0 is level |
| tmr_route | input | 15 | Per-timer 5-bit I/O line number; timer t uses bits [t*5+4:t*5] |
| pit_irq | input | 1 | Interval timer request |
| rtc_irq | input | 1 | Real-time clock request |
| pic_irq | output | 16 | Legacy controller input lines |
| io_irq | output | 24 | I/O interrupt controller input lines |

## Verification
The bench checks that the interval timer and the clock are silenced in replacement mode even while timers 0 and 1 are idle. A design that forgot this would leave `pic_irq[0]` or `pic_irq[8]` set with no timer request behind it. It also sends routes of 0, 2, 8, 19, 24 and 31. A decoder that did no capability check, or no range check, would raise lines 2 or 8 or wrap onto a line that does not exist.

For edge timers, the bench holds a request high for several cycles and also retriggers it right after a fall. A missing or stuck trigger machine would either hold the line or never pulse again.

The bench also flips the mode under the mask while `pit_irq` is high, and lets two level timers share line 21. A design that gated the mask late would leak one request cycle, and a design without the OR would lose one of the two sharers.

// File: rtl/tmr_route_pkg.sv
package tmr_route_pkg;

    typedef enum logic {
        TRIG_ARMED = 1'b0,
        TRIG_FIRED = 1'b1
    } trig_state_e;

    typedef enum logic {
        MODE_STANDARD = 1'b0,
        MODE_REPLACE  = 1'b1
    } route_mode_e;

endpackage

// File: rtl/tmr_trig_chan.sv
module tmr_trig_chan
    import tmr_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic edge_i,
    output logic req_o
);

    trig_state_e state_q;
    trig_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRIG_ARMED;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        req_o     = 1'b0;
        unique case (state_q)
            TRIG_ARMED: begin
                req_o = irq_i;
                if (irq_i) state_nxt = TRIG_FIRED;
            end
            TRIG_FIRED: begin
                req_o = edge_i ? 1'b0 : irq_i;
                if (!irq_i) state_nxt = TRIG_ARMED;
            end
            default: state_nxt = TRIG_ARMED;
        endcase
    end

    // R9: an edge-mode pulse never lasts two cycles
    assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && req_o) |=> !(edge_i && req_o));

endmodule

// File: rtl/tmr_route_decode.sv
module tmr_route_decode #(
    parameter int                 LINES   = 24,
    parameter int                 RW      = 5,
    parameter logic [LINES-1:0]   CAP     = 24'hF0_0000
) (
    input  logic [RW-1:0]    route_i,
    output logic [LINES-1:0] hit_o
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (CAP[i]) begin : g_allowed
            assign hit_o[i] = (route_i == RW'(i));
        end else begin : g_blocked
            assign hit_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
    import tmr_route_pkg::*;
#(
    parameter int                     N_TMR     = 3,
    parameter int                     PIC_LINES = 16,
    parameter int                     IO_LINES  = 24,
    parameter logic [IO_LINES-1:0]    ROUTE_CAP = 24'hF0_0000,
    parameter int                     PIC_T0    = 0,
    parameter int                     IO_T0     = 2,
    parameter int                     PIC_T1    = 8,
    parameter int                     IO_T1     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          legacy_replace,
    input  logic                          irq_mask,
    input  logic [N_TMR-1:0]              tmr_irq,
    input  logic [N_TMR-1:0]              tmr_edge,
    input  logic [N_TMR*$clog2(IO_LINES)-1:0] tmr_route,
    input  logic                          pit_irq,
    input  logic                          rtc_irq,
    output logic [PIC_LINES-1:0]          pic_irq,
    output logic [IO_LINES-1:0]           io_irq
);

    localparam int RW         = $clog2(IO_LINES);
    localparam int N_REPLACED = 2;

    route_mode_e           mode;
    logic [N_TMR-1:0]      chan_req;
    logic [IO_LINES-1:0]   dec_hit [N_TMR];
    logic [PIC_LINES-1:0]  pic_nxt;
    logic [IO_LINES-1:0]   io_nxt;

    assign mode = legacy_replace ? MODE_REPLACE : MODE_STANDARD;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        tmr_trig_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .irq_i  (tmr_irq[g]),
            .edge_i (tmr_edge[g]),
            .req_o  (chan_req[g])
        );

        tmr_route_decode #(
            .LINES (IO_LINES),
            .RW    (RW),
            .CAP   (ROUTE_CAP)
        ) u_dec (
            .route_i (tmr_route[g*RW +: RW]),
            .hit_o   (dec_hit[g])
        );

        // R7: a timer never lands on more than one line
        assert_route_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(dec_hit[g]));
    end

    always_comb begin
        pic_nxt = '0;
        io_nxt  = '0;
        unique case (mode)
            MODE_REPLACE: begin
                if (chan_req[0]) begin
                    pic_nxt[PIC_T0] = 1'b1;
                    io_nxt[IO_T0]   = 1'b1;
                end
                if (chan_req[1]) begin
                    pic_nxt[PIC_T1] = 1'b1;
                    io_nxt[IO_T1]   = 1'b1;
                end
                for (int t = N_REPLACED; t < N_TMR; t++) begin
                    if (chan_req[t]) io_nxt = io_nxt | dec_hit[t];
                end
            end
            MODE_STANDARD: begin
                if (pit_irq) begin
                    pic_nxt[PIC_T0] = 1'b1;
                    io_nxt[IO_T0]   = 1'b1;
                end
                if (rtc_irq) begin
                    pic_nxt[PIC_T1] = 1'b1;
                    io_nxt[IO_T1]   = 1'b1;
                end
                for (int t = 0; t < N_TMR; t++) begin
                    if (chan_req[t]) io_nxt = io_nxt | dec_hit[t];
                end
            end
            default: ;
        endcase
        if (irq_mask) begin
            pic_nxt = '0;
            io_nxt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pic_irq <= '0;
            io_irq  <= '0;
        end else begin
            pic_irq <= pic_nxt;
            io_irq  <= io_nxt;
        end
    end

    // R10: mask silences every line one edge later
    assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |=> (pic_irq == '0 && io_irq == '0));

    // R2: interval timer silenced in replacement mode
    assert_pit_silenced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_replace && !chan_req[0]) |=> !pic_irq[PIC_T0]);

    // R3: clock source silenced in replacement mode
    assert_rtc_silenced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_replace && !chan_req[1]) |=> !pic_irq[PIC_T1]);

    // R5: timers never reach the legacy controller in standard mode
    assert_no_pic_std_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_replace && !pit_irq && !rtc_irq) |=> (pic_irq == '0));

endmodule

// File: tb/tmr_irq_router_tb.sv
module tmr_irq_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_replace = 1'b0;
    logic        irq_mask = 1'b0;
    logic [2:0]  tmr_irq = '0;
    logic [2:0]  tmr_edge = '0;
    logic [14:0] tmr_route = '0;
    logic        pit_irq = 1'b0;
    logic        rtc_irq = 1'b0;
    logic [15:0] pic_irq;
    logic [23:0] io_irq;

    int checks = 0;
    int errors = 0;
    string req_tag = "R1";
    bit done = 1'b0;

    logic [15:0] exp_pic = '0;
    logic [23:0] exp_io = '0;
    logic [2:0]  prev_irq = '0;

    always #5 clk = ~clk;

    tmr_irq_router u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .legacy_replace (legacy_replace),
        .irq_mask       (irq_mask),
        .tmr_irq        (tmr_irq),
        .tmr_edge       (tmr_edge),
        .tmr_route      (tmr_route),
        .pit_irq        (pit_irq),
        .rtc_irq        (rtc_irq),
        .pic_irq        (pic_irq),
        .io_irq         (io_irq)
    );

    // behavioural reference, updated on every rising edge
    always @(posedge clk) begin : ref_model
        logic [15:0] p;
        logic [23:0] v;
        logic [2:0]  rq;
        int          first;
        int          r;
        if (!rst_n) begin
            exp_pic  <= '0;
            exp_io   <= '0;
            prev_irq <= '0;
        end else begin
            p = '0;
            v = '0;
            for (int t = 0; t < 3; t++)
                rq[t] = tmr_edge[t] ? (tmr_irq[t] && !prev_irq[t]) : tmr_irq[t];
            if (legacy_replace) begin
                if (rq[0]) begin p[0] = 1'b1; v[2] = 1'b1; end
                if (rq[1]) begin p[8] = 1'b1; v[8] = 1'b1; end
                first = 2;
            end else begin
                if (pit_irq) begin p[0] = 1'b1; v[2] = 1'b1; end
                if (rtc_irq) begin p[8] = 1'b1; v[8] = 1'b1; end
                first = 0;
            end
            for (int t = first; t < 3; t++) begin
                r = int'(tmr_route[t*5 +: 5]);
                if (rq[t] && r >= 20 && r <= 23) v[r] = 1'b1;
            end
            if (irq_mask) begin p = '0; v = '0; end
            exp_pic  <= p;
            exp_io   <= v;
            prev_irq <= tmr_irq;
        end
    end

    task automatic compare();
        checks++;
        if (pic_irq !== exp_pic || io_irq !== exp_io) begin
            errors++;
            $display("FAIL %s pic=%h io=%h expected pic=%h io=%h",
                     req_tag, pic_irq, io_irq, exp_pic, exp_io);
        end
    endtask

    // advance one clock, then compare at the falling edge
    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    function automatic logic [14:0] routes(int a, int b, int c);
        return {5'(c), 5'(b), 5'(a)};
    endfunction

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state
        req_tag = "R1";
        tmr_irq = 3'b111; pit_irq = 1'b1; rtc_irq = 1'b1;
        tmr_route = routes(20, 21, 22);
        cyc(3);
        tmr_irq = '0; pit_irq = 1'b0; rtc_irq = 1'b0;
        rst_n = 1'b1;
        cyc(2);

        // R5: standard routing, each timer alone
        req_tag = "R5";
        tmr_route = routes(20, 21, 23);
        for (int t = 0; t < 3; t++) begin
            tmr_irq = 3'(1 << t);
            cyc(2);
        end
        tmr_route = routes(23, 22, 20);
        tmr_irq = 3'b111;
        cyc(2);
        tmr_irq = '0;
        cyc(1);

        // R6: older sources in standard mode
        req_tag = "R6";
        pit_irq = 1'b1; cyc(2);
        rtc_irq = 1'b1; pit_irq = 1'b0; cyc(2);
        pit_irq = 1'b1; cyc(1);
        pit_irq = 1'b0; rtc_irq = 1'b0; cyc(1);

        // R7: routes not advertised by the capability mask
        req_tag = "R7";
        tmr_irq = 3'b111;
        tmr_route = routes(0, 2, 8);   cyc(2);
        tmr_route = routes(19, 24, 31); cyc(2);
        tmr_route = routes(20, 24, 23); cyc(2);
        tmr_irq = '0; cyc(1);

        // R8: level timers sharing line 21
        req_tag = "R8";
        tmr_route = routes(21, 21, 22);
        tmr_irq = 3'b001; cyc(2);
        tmr_irq = 3'b011; cyc(2);
        tmr_irq = 3'b010; cyc(2);
        tmr_irq = '0; cyc(1);

        // R9: edge mode pulses
        req_tag = "R9";
        tmr_edge = 3'b101;
        tmr_route = routes(20, 21, 22);
        tmr_irq = 3'b111; cyc(4);
        tmr_irq = 3'b000; cyc(1);
        tmr_irq = 3'b101; cyc(1);
        tmr_irq = 3'b000; cyc(1);
        tmr_irq = 3'b001; cyc(3);
        tmr_irq = '0; tmr_edge = '0; cyc(1);

        // R2 / R3: replacement mode, sources silenced while timers idle
        req_tag = "R2";
        legacy_replace = 1'b1;
        pit_irq = 1'b1; rtc_irq = 1'b1; cyc(2);
        tmr_irq = 3'b001; cyc(2);
        req_tag = "R3";
        tmr_irq = 3'b010; cyc(2);
        tmr_irq = 3'b011; cyc(2);

        // R4: timer 2 keeps its route in replacement mode
        req_tag = "R4";
        tmr_route = routes(22, 23, 23);
        tmr_irq = 3'b100; cyc(2);
        tmr_route = routes(20, 20, 8);  cyc(2);
        tmr_route = routes(20, 20, 21); tmr_irq = 3'b111; cyc(2);
        tmr_irq = '0; cyc(1);

        // R10: mask around a mode change with the interval timer high
        req_tag = "R10";
        irq_mask = 1'b1; pit_irq = 1'b1; cyc(1);
        legacy_replace = 1'b0; cyc(2);
        tmr_edge = 3'b001; tmr_route = routes(20, 21, 22);
        tmr_irq = 3'b001; cyc(2);
        irq_mask = 1'b0; cyc(2);
        tmr_irq = 3'b000; pit_irq = 1'b0; tmr_edge = '0; cyc(1);

        // R11: one-edge latency on a fast toggle
        req_tag = "R11";
        for (int i = 0; i < 6; i++) begin
            rtc_irq = i[0];
            tmr_irq = {i[0], 1'b0, ~i[0]};
            cyc(1);
        end
        rtc_irq = 1'b0; tmr_irq = '0; cyc(1);

        // mixed traffic across all requirements (R2 to R10)
        req_tag = "R8";
        for (int i = 0; i < 400; i++) begin
            legacy_replace = 1'($urandom_range(0, 1));
            irq_mask       = ($urandom_range(0, 7) == 0);
            tmr_irq        = 3'($urandom);
            tmr_edge       = 3'($urandom);
            pit_irq        = 1'($urandom);
            rtc_irq        = 1'($urandom);
            tmr_route      = routes($urandom_range(18, 25), $urandom_range(18, 25),
                                    $urandom_range(18, 25));
            cyc(1);
        end

        // R1: reset again in the middle of traffic
        req_tag = "R1";
        rst_n = 1'b0; cyc(2);
        legacy_replace = 1'b0; irq_mask = 1'b0; tmr_irq = '0;
        pit_irq = 1'b0; rtc_irq = 1'b0;
        rst_n = 1'b1; cyc(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule